// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a byte-wide 128K x 8 flash device, written as synchronous logic. It watches the active-low chip select, output enable and write strobe together with a 17-bit address and an 8-bit data bus. It recognises the standard multi-write unlock sequences built on two fixed unlock addresses. When a sequence completes, it issues a single-cycle start pulse for a byte program, a page erase or a chip erase. Each pulse comes with the latched target address and data byte. The memory array and the high-voltage timers sit outside the block and consume these pulses.

The block also keeps a read-mode select that tells the outer data-bus multiplexer whether reads come from the array or from the identification bytes. It supplies the identification byte for the current read address. A protection input fences off 32 pages of 512 bytes each, either at the top or at the bottom of the array, depending on a build parameter. The write strobes are assumed to be synchronous to the clock already. A strobe window shorter than a parameterised number of cycles is treated as a glitch.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, all three start pulses are low and the read-mode select is 0 (array reads).
- R2: A write window is the span of cycles in which chip select and write strobe are both low and output enable is high. A window shorter than GLITCH_CYC cycles is ignored entirely and leaves the sequence position unchanged.
- R3: A window is discarded if output enable is low, whether low for the whole window or falling before chip select or write strobe rises. Such a window leaves the sequence position unchanged.
- R4: The address is taken in the first cycle of a window. The data is taken in the last cycle of the window.
- R5: The writes AAh@5555h, 55h@2AAAh, A0h@5555h, then D@A pulse prog_start for one cycle, one cycle after the last window closes, with op_addr=A and op_data=D. The final write is taken as data whatever its value.
- R6: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 30h at any address pulse page_erase_start, with op_addr set to that address.
- R7: The same five-write prefix followed by 10h@5555h pulses chip_erase_start.
- R8: A write that does not match the next expected step returns the decoder to idle with no pulse. A fresh sequence started afterwards still works.
- R9: Unlock addresses are compared on address bits 14..0 only. Bits 16 and 15 are ignored.
- R10: The writes AAh@5555h, 55h@2AAAh, 90h@5555h set rd_sel to 1. In that mode id_byte depends on address bits 1..0: 00 gives 7Fh, 11 gives 1Fh, 01 gives A5h for the top variant or A6h for the bottom variant, and 10 gives the protection input on bit 0.
- R11: Writing F0h to any address, at any point except the data write of a program, sets rd_sel to 0 and returns the decoder to idle.
- R12: With prot_en high, program and page erase aimed at a protected page start nothing. A page is address bits 16..9. The protected pages are 224..255 for the top variant and 0..31 for the bottom variant. With prot_en low, every page is open.
- R13: With prot_en high, a chip erase sequence starts nothing.
- R14: At most one start pulse is high in any cycle, and each pulse lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | 17 | Byte address |
| din | input | 8 | Write data bus |
| prot_en | input | 1 | Hardwired page protection enabled |
| prog_start | output | 1 | One-cycle byte program start |
| page_erase_start | output | 1 | One-cycle page erase start |
| chip_erase_start | output | 1 | One-cycle chip erase start |
| op_addr | output | 17 | Latched address of the started operation |
| op_data | output | 8 | Latched data byte of the started operation |
| rd_sel | output | 1 | Read source select: 0 array, 1 identification |
| id_byte | output | 8 | Identification byte for the current read address |

## Verification
The bench builds two copies side by side on one shared bus. The first copy is the top variant with GLITCH_CYC=3. The second is the bottom variant with GLITCH_CYC=2. Each operation therefore shows both protection fences and both device identification codes at the same time: the same address can be blocked in one copy and allowed in the other. The shared page boundaries 223/224 and 31/32 are hit directly. A one-cycle strobe sits under both glitch thresholds, while the four-cycle strobes used elsewhere clear both.

// File: rtl/flash_cmd_pkg.sv
// Shared constants and types for the flash command decoder.
// Assumes byte-wide data; command codes are fixed 8-bit values.
package flash_cmd_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_READ, ST_C1, ST_C2, ST_PGM, ST_E3, ST_E4, ST_E5
    } seq_state_t;

    localparam logic [14:0] UNLOCK_A = 15'h5555;
    localparam logic [14:0] UNLOCK_B = 15'h2AAA;

    localparam logic [BYTE_W-1:0] CD_AA    = 8'hAA;
    localparam logic [BYTE_W-1:0] CD_55    = 8'h55;
    localparam logic [BYTE_W-1:0] CD_PGM   = 8'hA0;
    localparam logic [BYTE_W-1:0] CD_ERS   = 8'h80;
    localparam logic [BYTE_W-1:0] CD_IDENT = 8'h90;
    localparam logic [BYTE_W-1:0] CD_RESET = 8'hF0;
    localparam logic [BYTE_W-1:0] CD_PAGE  = 8'h30;
    localparam logic [BYTE_W-1:0] CD_CHIP  = 8'h10;

    localparam logic [BYTE_W-1:0] ID_MFR1    = 8'h7F;
    localparam logic [BYTE_W-1:0] ID_MFR2    = 8'h1F;
    localparam logic [BYTE_W-1:0] ID_DEV_TOP = 8'hA5;
    localparam logic [BYTE_W-1:0] ID_DEV_BOT = 8'hA6;
endpackage

// File: rtl/flash_wr_sampler.sv
// Turns the strobe pins into qualified write events.
// Assumes the strobes are already synchronous to clk. A window is the
// run of cycles with ce_n=0, we_n=0, oe_n=1. The address is captured in
// the first cycle and the data in the last. A window shorter than
// GLITCH_CYC cycles, or one ended by oe_n falling, yields no event.
module flash_wr_sampler
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int GLITCH_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] din,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data
);
    localparam int CNT_W = $clog2(GLITCH_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(GLITCH_CYC);

    logic              act, act_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] data_q;

    assign act = !ce_n && !we_n && oe_n;

    // Track the window: first-cycle address, saturating width, last data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            cnt_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            act_q <= act;
            if (act && !act_q) begin
                addr_q <= addr;
                cnt_q  <= CNT_W'(1);
            end else if (act && cnt_q < CNT_MAX) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
            if (act) data_q <= din;
        end
    end

    // Accept at the closing edge only when a strobe ended it and it was long enough.
    always_comb begin
        wr_valid = act_q && !act && oe_n && (ce_n || we_n) && (cnt_q >= CNT_MAX);
        wr_addr  = addr_q;
        wr_data  = data_q;
    end

    a_r3_oe_high_at_close: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $past(oe_n));
    a_r2_window_seen: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> ($past(!ce_n) && $past(!we_n)));
endmodule

// File: rtl/flash_page_guard.sv
// Decides whether an address falls in the protected page region.
// The page index is the address above the in-page offset. The protected
// region is PROT_PAGES pages at the top or at the bottom of the array.
module flash_page_guard #(
    parameter int ADDR_W      = 17,
    parameter int PAGE_OFF_W  = 9,
    parameter int PROT_PAGES  = 32,
    parameter bit TOP_VARIANT = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              prot_en,
    output logic              page_locked
);
    localparam int PAGE_W    = ADDR_W - PAGE_OFF_W;
    localparam int NUM_PAGES = 1 << PAGE_W;

    logic [PAGE_W-1:0] page;
    assign page = addr[ADDR_W-1:PAGE_OFF_W];

    generate
        if (TOP_VARIANT) begin : g_top
            // Top fence: the highest PROT_PAGES pages.
            always_comb page_locked = prot_en && (page >= PAGE_W'(NUM_PAGES - PROT_PAGES));
        end else begin : g_bot
            // Bottom fence: the lowest PROT_PAGES pages.
            always_comb page_locked = prot_en && (page < PAGE_W'(PROT_PAGES));
        end
    endgenerate
endmodule

// File: rtl/flash_id_rom.sv
// Identification byte lookup keyed by the two low read-address bits.
// Selector 10 exposes the protection state on bit 0.
module flash_id_rom
    import flash_cmd_pkg::*;
#(
    parameter bit TOP_VARIANT = 1'b1
) (
    input  logic [1:0]        sel,
    input  logic              prot_en,
    output logic [BYTE_W-1:0] id_byte
);
    localparam logic [BYTE_W-1:0] DEV_CODE = TOP_VARIANT ? ID_DEV_TOP : ID_DEV_BOT;

    // Select the identification byte.
    always_comb begin
        case (sel)
            2'b00:   id_byte = ID_MFR1;
            2'b01:   id_byte = DEV_CODE;
            2'b11:   id_byte = ID_MFR2;
            default: id_byte = {{(BYTE_W-1){1'b0}}, prot_en};
        endcase
    end
endmodule

// File: rtl/flash_seq_fsm.sv
// Tracks the unlock sequences and fires operation start pulses.
// Acts only on qualified write events. F0h resets to idle except in the
// program data slot. A mismatched step drops to idle silently. Pulses
// and the latched address/data are registered.
module flash_seq_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              page_locked,
    input  logic              prot_en,
    output logic              prog_start,
    output logic              page_erase_start,
    output logic              chip_erase_start,
    output logic [ADDR_W-1:0] op_addr,
    output logic [BYTE_W-1:0] op_data,
    output logic              id_mode
);
    seq_state_t state, nxt_state;
    logic nxt_id, fire_prog, fire_pe, fire_ce, is_a, is_b;

    assign is_a = (wr_addr[14:0] == UNLOCK_A);
    assign is_b = (wr_addr[14:0] == UNLOCK_B);

    // Next-step decode for the current write event.
    always_comb begin
        nxt_state = state;
        nxt_id    = id_mode;
        fire_prog = 1'b0;
        fire_pe   = 1'b0;
        fire_ce   = 1'b0;
        if (wr_valid) begin
            if (state != ST_PGM && wr_data == CD_RESET) begin
                nxt_state = ST_READ;
                nxt_id    = 1'b0;
            end else begin
                case (state)
                    ST_READ: nxt_state = (is_a && wr_data == CD_AA) ? ST_C1 : ST_READ;
                    ST_C1:   nxt_state = (is_b && wr_data == CD_55) ? ST_C2 : ST_READ;
                    ST_C2: begin
                        nxt_state = ST_READ;
                        if (is_a) begin
                            if (wr_data == CD_PGM)        nxt_state = ST_PGM;
                            else if (wr_data == CD_ERS)   nxt_state = ST_E3;
                            else if (wr_data == CD_IDENT) nxt_id    = 1'b1;
                        end
                    end
                    ST_PGM: begin
                        nxt_state = ST_READ;
                        fire_prog = !page_locked;
                    end
                    ST_E3:   nxt_state = (is_a && wr_data == CD_AA) ? ST_E4 : ST_READ;
                    ST_E4:   nxt_state = (is_b && wr_data == CD_55) ? ST_E5 : ST_READ;
                    ST_E5: begin
                        nxt_state = ST_READ;
                        if (wr_data == CD_PAGE)               fire_pe = !page_locked;
                        else if (wr_data == CD_CHIP && is_a)  fire_ce = !prot_en;
                    end
                    default: nxt_state = ST_READ;
                endcase
            end
        end
    end

    // State, mode flag, pulses and operation latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state            <= ST_READ;
            id_mode          <= 1'b0;
            prog_start       <= 1'b0;
            page_erase_start <= 1'b0;
            chip_erase_start <= 1'b0;
            op_addr          <= '0;
            op_data          <= '0;
        end else begin
            state            <= nxt_state;
            id_mode          <= nxt_id;
            prog_start       <= fire_prog;
            page_erase_start <= fire_pe;
            chip_erase_start <= fire_ce;
            if (fire_prog || fire_pe || fire_ce) begin
                op_addr <= wr_addr;
                op_data <= wr_data;
            end
        end
    end

    a_r14_onehot_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_start, page_erase_start, chip_erase_start}));
    a_r14_single_prog: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |=> !prog_start);
    a_r13_chip_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
        chip_erase_start |-> !$past(prot_en));
    a_r12_prog_not_locked: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> !$past(page_locked));
    a_r12_page_not_locked: assert property (@(posedge clk) disable iff (!rst_n)
        page_erase_start |-> !$past(page_locked));
    a_r10_id_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(id_mode) |-> $past(wr_valid && wr_data == CD_IDENT));
    a_r11_reset_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_data == CD_RESET && state != ST_PGM) |=> !id_mode);
endmodule

// File: rtl/flash_cmd_decoder.sv
// Top of the flash command decoder: write qualification, sequence
// tracking, page protection and identification read data.
// Assumes all pins are synchronous to clk.
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W      = 17,
    parameter int PAGE_OFF_W  = 9,
    parameter int PROT_PAGES  = 32,
    parameter bit TOP_VARIANT = 1'b1,
    parameter int GLITCH_CYC  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] din,
    input  logic              prot_en,
    output logic              prog_start,
    output logic              page_erase_start,
    output logic              chip_erase_start,
    output logic [ADDR_W-1:0] op_addr,
    output logic [BYTE_W-1:0] op_data,
    output logic              rd_sel,
    output logic [BYTE_W-1:0] id_byte
);
    logic              wr_valid, page_locked;
    logic [ADDR_W-1:0] wr_addr;
    logic [BYTE_W-1:0] wr_data;

    flash_wr_sampler #(.ADDR_W(ADDR_W), .GLITCH_CYC(GLITCH_CYC)) u_sampler (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    flash_page_guard #(.ADDR_W(ADDR_W), .PAGE_OFF_W(PAGE_OFF_W),
                       .PROT_PAGES(PROT_PAGES), .TOP_VARIANT(TOP_VARIANT)) u_guard (
        .addr(wr_addr), .prot_en(prot_en), .page_locked(page_locked)
    );

    flash_seq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .page_locked(page_locked), .prot_en(prot_en),
        .prog_start(prog_start), .page_erase_start(page_erase_start),
        .chip_erase_start(chip_erase_start), .op_addr(op_addr),
        .op_data(op_data), .id_mode(rd_sel)
    );

    flash_id_rom #(.TOP_VARIANT(TOP_VARIANT)) u_id (
        .sel(addr[1:0]), .prot_en(prot_en), .id_byte(id_byte)
    );
endmodule

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, prot_en = 1'b0;
    logic [16:0] addr = '0;
    logic [7:0]  din = '0;

    logic t_pg, t_pe, t_ce, t_sel, b_pg, b_pe, b_ce, b_sel;
    logic [16:0] t_addr, b_addr;
    logic [7:0]  t_data, b_data, t_id, b_id;

    int checks = 0, fails = 0;
    logic [2:0]  pt, pb;
    logic [16:0] at, ab;
    logic [7:0]  dt, db;

    always #2 clk = ~clk;

    flash_cmd_decoder #(.TOP_VARIANT(1'b1), .GLITCH_CYC(3)) u_flash_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .prot_en(prot_en),
        .prog_start(t_pg), .page_erase_start(t_pe), .chip_erase_start(t_ce),
        .op_addr(t_addr), .op_data(t_data), .rd_sel(t_sel), .id_byte(t_id));

    flash_cmd_decoder #(.TOP_VARIANT(1'b0), .GLITCH_CYC(2)) u_flash_cmd_decoder_bot (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .prot_en(prot_en),
        .prog_start(b_pg), .page_erase_start(b_pe), .chip_erase_start(b_ce),
        .op_addr(b_addr), .op_data(b_data), .rd_sel(b_sel), .id_byte(b_id));

    function automatic bit locked(bit top, logic [16:0] a, bit p);
        logic [7:0] pg = a[16:9];
        return p && (top ? (pg >= 8'd224) : (pg < 8'd32));
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Close the window, capture pulses one cycle later, then confirm they drop (R14).
    task automatic close_and_capture();
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        pt = {t_pg, t_pe, t_ce}; pb = {b_pg, b_pe, b_ce};
        at = t_addr; ab = b_addr; dt = t_data; db = b_data;
        @(negedge clk);
        chk("R14 pulses single cycle", {t_pg, t_pe, t_ce, b_pg, b_pe, b_ce}, 0);
    endtask

    task automatic wr(input logic [16:0] a, input logic [7:0] d, input int len);
        @(negedge clk);
        addr = a; din = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        repeat (len) @(negedge clk);
        close_and_capture();
    endtask

    task automatic unlock2();
        wr(17'h05555, 8'hAA, 4);
        wr(17'h02AAA, 8'h55, 4);
    endtask

    task automatic erase_prefix();
        unlock2(); wr(17'h05555, 8'h80, 4); unlock2();
    endtask

    task automatic expect_pulses(input string tag, input logic [2:0] et, input logic [2:0] eb);
        chk({tag, " top"}, pt, et);
        chk({tag, " bottom"}, pb, eb);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset pulses", {t_pg, t_pe, t_ce, b_pg, b_pe, b_ce}, 0);
        chk("R1 reset rd_sel", {t_sel, b_sel}, 0);

        // R5 byte program
        unlock2(); wr(17'h05555, 8'hA0, 4); wr(17'h12345, 8'h5A, 4);
        expect_pulses("R5 program", 3'b100, 3'b100);
        chk("R5 op_addr", at, 17'h12345);
        chk("R5 op_data", dt, 8'h5A);

        // R6 page erase at any address
        erase_prefix(); wr(17'h04321, 8'h30, 4);
        expect_pulses("R6 page erase", 3'b010, 3'b010);
        chk("R6 op_addr", ab, 17'h04321);

        // R7 chip erase
        erase_prefix(); wr(17'h05555, 8'h10, 4);
        expect_pulses("R7 chip erase", 3'b001, 3'b001);

        // R9 upper address bits ignored in unlock compare
        wr(17'h1D555, 8'hAA, 4); wr(17'h1AAAA, 8'h55, 4); wr(17'h0D555, 8'hA0, 4);
        wr(17'h00777, 8'hC3, 4);
        expect_pulses("R9 high bits ignored", 3'b100, 3'b100);

        // R8 broken sequence
        unlock2(); wr(17'h05555, 8'h77, 4); wr(17'h05555, 8'hA0, 4); wr(17'h00100, 8'h5A, 4);
        expect_pulses("R8 broken sequence", 3'b000, 3'b000);
        unlock2(); wr(17'h05555, 8'hA0, 4); wr(17'h00100, 8'h5A, 4);
        expect_pulses("R8 recovery", 3'b100, 3'b100);

        // R2 short window ignored, sequence position kept
        unlock2(); wr(17'h05555, 8'hA0, 4); wr(17'h00200, 8'h11, 1);
        expect_pulses("R2 glitch", 3'b000, 3'b000);
        wr(17'h00300, 8'h22, 4);
        expect_pulses("R2 after glitch", 3'b100, 3'b100);
        chk("R2 data after glitch", dt, 8'h22);

        // R3 output enable low the whole window
        unlock2(); wr(17'h05555, 8'hA0, 4);
        @(negedge clk); addr = 17'h00400; din = 8'h33; oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b0;
        repeat (4) @(negedge clk);
        close_and_capture();
        expect_pulses("R3 oe low", 3'b000, 3'b000);
        // R3 output enable falling before the strobes rise
        @(negedge clk); addr = 17'h00500; din = 8'h44; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        repeat (3) @(negedge clk); oe_n = 1'b0;
        repeat (2) @(negedge clk);
        close_and_capture();
        expect_pulses("R3 oe fall", 3'b000, 3'b000);
        wr(17'h00600, 8'h55, 4);
        expect_pulses("R3 after inhibit", 3'b100, 3'b100);
        chk("R3 op_addr", at, 17'h00600);

        // R4 address from first cycle, data from last cycle
        unlock2(); wr(17'h05555, 8'hA0, 4);
        @(negedge clk); addr = 17'h0ABCD; din = 8'h01; ce_n = 1'b0; we_n = 1'b0;
        repeat (2) @(negedge clk); addr = 17'h01111; din = 8'hE7;
        repeat (2) @(negedge clk);
        close_and_capture();
        chk("R4 address first cycle", at, 17'h0ABCD);
        chk("R4 data last cycle", db, 8'hE7);

        // R10 identification mode
        unlock2(); wr(17'h05555, 8'h90, 4);
        chk("R10 rd_sel", {t_sel, b_sel}, 2'b11);
        @(negedge clk); addr = 17'h00000; @(negedge clk);
        chk("R10 mfr byte 1", {t_id, b_id}, 16'h7F7F);
        addr = 17'h00003; @(negedge clk);
        chk("R10 mfr byte 2", {t_id, b_id}, 16'h1F1F);
        addr = 17'h00001; @(negedge clk);
        chk("R10 device code", {t_id, b_id}, 16'hA5A6);
        addr = 17'h00002; prot_en = 1'b1; @(negedge clk);
        chk("R10 protect bit set", {t_id[0], b_id[0]}, 2'b11);
        prot_en = 1'b0; @(negedge clk);
        chk("R10 protect bit clear", {t_id[0], b_id[0]}, 2'b00);

        // R11 exit by F0
        wr(17'h00123, 8'hF0, 4);
        chk("R11 rd_sel cleared", {t_sel, b_sel}, 2'b00);
        unlock2(); wr(17'h00999, 8'hF0, 4); wr(17'h05555, 8'hA0, 4); wr(17'h00010, 8'h66, 4);
        expect_pulses("R11 F0 mid sequence", 3'b000, 3'b000);

        // R12 page fence boundaries
        prot_en = 1'b1;
        unlock2(); wr(17'h05555, 8'hA0, 4); wr(17'h1FF00, 8'h12, 4);
        expect_pulses("R12 page 255", 3'b000, 3'b100);
        unlock2(); wr(17'h05555, 8'hA0, 4); wr(17'h00010, 8'h12, 4);
        expect_pulses("R12 page 0", 3'b100, 3'b000);
        erase_prefix(); wr(17'h1C000, 8'h30, 4);
        expect_pulses("R12 page 224", 3'b000, 3'b010);
        erase_prefix(); wr(17'h1BFFF, 8'h30, 4);
        expect_pulses("R12 page 223", 3'b010, 3'b010);
        erase_prefix(); wr(17'h03FFF, 8'h30, 4);
        expect_pulses("R12 page 31", 3'b010, 3'b000);
        erase_prefix(); wr(17'h04000, 8'h30, 4);
        expect_pulses("R12 page 32", 3'b010, 3'b010);

        // R13 chip erase blocked
        erase_prefix(); wr(17'h05555, 8'h10, 4);
        expect_pulses("R13 chip blocked", 3'b000, 3'b000);
        prot_en = 1'b0;

        // R12 random mix of program and page erase across fences
        for (int i = 0; i < 40; i++) begin
            int kind = $urandom % 3;
            logic [7:0]  pg;
            logic [16:0] a;
            logic [7:0]  d;
            bit p, is_prog;
            pg = (kind == 0) ? 8'($urandom) : (kind == 1) ? 8'(224 + $urandom % 32) : 8'($urandom % 32);
            a = {pg, 9'($urandom)};
            d = 8'($urandom);
            p = 1'($urandom);
            is_prog = 1'($urandom);
            prot_en = p;
            if (is_prog) begin
                unlock2(); wr(17'h05555, 8'hA0, 4); wr(a, d, 4);
                expect_pulses("R12 random program", {!locked(1'b1, a, p), 2'b00},
                              {!locked(1'b0, a, p), 2'b00});
                if (!locked(1'b1, a, p)) chk("R5 random data", dt, d);
            end else begin
                erase_prefix(); wr(a, 8'h30, 4);
                expect_pulses("R12 random erase", {1'b0, !locked(1'b1, a, p), 1'b0},
                              {1'b0, !locked(1'b0, a, p), 1'b0});
                if (!locked(1'b0, a, p)) chk("R6 random addr", ab, a);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule